// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block copies a run of 32-bit words from one memory region to another without the processor touching the data. Software uses a small register port to load a source address, a destination address and a byte length, then sets a start bit. The engine raises a bus request and waits for the grant. It then moves the words one beat at a time. Each beat reads one word through a read master and writes that same word through a separate write master. The engine steps both addresses by four bytes after each beat.

When the last write is accepted, or when either master port returns an error, the engine drops its bus request and sets a sticky done flag. On an error it also sets an error flag. If interrupts are enabled, the done flag drives the interrupt line. The engine runs one job at a time. Programming and start writes have no effect while a job runs, and they stay blocked until software clears the done flag.

The sequencer has four states. IDLE waits for a start. ARB holds the bus request until the grant arrives. READ holds a read request until the read acknowledge. WRITE holds a write request until the write acknowledge. The transitions are:
- IDLE to ARB on a start with a valid length.
- ARB to READ on grant.
- READ to WRITE on a clean read acknowledge.
- READ to IDLE on a read error.
- WRITE to READ on a clean acknowledge when words remain.
- WRITE to IDLE on the final acknowledge or on a write error.

A start with a bad length stays in IDLE and completes at once with an error.

Top module: `dma_mm_engine`

## Requirements
- R1: Registers sit at byte offsets 0x00 (source address), 0x04 (destination address), 0x08 (length in bytes), 0x0C (control) and 0x10 (status). Control bit 0 is start (write-only, reads 0) and control bit 1 is interrupt enable. Status bit 0 is busy, bit 1 is done and bit 2 is error. All registers, irq and bus_req are 0 after reset. Accesses with cfg_addr[1:0] nonzero are ignored.
- R2: A start with a valid length makes status busy read 1 and bus_req read 1 in the next cycle. rd_req and wr_req are never high unless bus_gnt is high.
- R3: Beat k reads address source+4k. Each write goes to destination+4k, carries the data returned by the matching read, and is issued only after that read is acknowledged.
- R4: A pending rd_req keeps rd_addr stable until rd_ack. A pending wr_req keeps wr_addr and wr_data stable until wr_ack.
- R5: In the cycle after the final wr_ack, bus_req is 0, busy is 0 and done is 1 with error 0.
- R6: irq equals done AND interrupt enable. Writing 1 to status bit 1 clears done, error and irq.
- R7: A start with a length of zero, or a length that is not a multiple of 4, sets done and error in the next cycle. No bus_req is raised.
- R8: An acknowledge that carries rd_err or wr_err ends the job. No further beats are issued, done and error are set, and bus_req is 0 in the next cycle.
- R9: While busy or done is set, writes to the source, destination and length registers and to the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sel | input | 1 | Register port select |
| cfg_wr | input | 1 | Register port write (1) or read (0) |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| rd_req | output | 1 | Read request, held until rd_ack |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | DATA_W | Read data |
| rd_err | input | 1 | Read error, qualified by rd_ack |
| wr_req | output | 1 | Write request, held until wr_ack |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, qualified by wr_ack |

## Verification
Several faults show at the ports within one beat:
- A stale working address or a skipped step writes to the wrong destination word. The bench checks every read and write address as it is acknowledged.
- A wrong remaining count ends the job a beat early or late. That changes the beat count and the cycle in which bus_req falls, and the bench checks the cycle right after the last write acknowledge.
- A done flag that fails to lock the registers lets a second start raise bus_req within a cycle.
- A missing error capture leaves status bit 2 clear one cycle after the faulty acknowledge.

// File: rtl/dma_mm_pkg.sv
package dma_mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_READ,
        ST_WRITE
    } xfer_state_t;

    // register word indices (byte offset / 4)
    localparam int REG_SRC  = 0;
    localparam int REG_DST  = 1;
    localparam int REG_LEN  = 2;
    localparam int REG_CTRL = 3;
    localparam int REG_STAT = 4;

    // control and status bit positions
    localparam int CTRL_GO   = 0;
    localparam int CTRL_IEN  = 1;
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_mm_pkg::*;
#(
    parameter int CFG_AW = 5,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              eng_busy,
    input  logic              fin,
    input  logic              fin_err,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              go,
    output logic              done_q,
    output logic              err_q,
    output logic              irq
);
    localparam int IDX_W = CFG_AW - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_en;
    logic             locked;
    logic             ien_q;

    assign idx     = cfg_addr[CFG_AW-1:2];
    assign aligned = (cfg_addr[1:0] == 2'b00);
    assign wr_en   = cfg_sel && cfg_wr && aligned;
    assign locked  = eng_busy || done_q;
    assign go      = wr_en && (idx == IDX_W'(REG_CTRL)) && cfg_wdata[CTRL_GO] && !locked;
    assign irq     = done_q && ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            ien_q <= 1'b0;
        end else if (wr_en) begin
            if (idx == IDX_W'(REG_SRC) && !locked) src_q <= cfg_wdata[ADDR_W-1:0];
            if (idx == IDX_W'(REG_DST) && !locked) dst_q <= cfg_wdata[ADDR_W-1:0];
            if (idx == IDX_W'(REG_LEN) && !locked) len_q <= cfg_wdata[LEN_W-1:0];
            if (idx == IDX_W'(REG_CTRL))           ien_q <= cfg_wdata[CTRL_IEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (fin) begin
            done_q <= 1'b1;
            err_q  <= fin_err;
        end else if (wr_en && idx == IDX_W'(REG_STAT) && cfg_wdata[STAT_DONE]) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(REG_SRC):  cfg_rdata = 32'(src_q);
                IDX_W'(REG_DST):  cfg_rdata = 32'(dst_q);
                IDX_W'(REG_LEN):  cfg_rdata = 32'(len_q);
                IDX_W'(REG_CTRL): cfg_rdata[CTRL_IEN] = ien_q;
                IDX_W'(REG_STAT): begin
                    cfg_rdata[STAT_BUSY] = eng_busy;
                    cfg_rdata[STAT_DONE] = done_q;
                    cfg_rdata[STAT_ERR]  = err_q;
                end
                default: cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              step,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              last
);
    localparam int BEAT_BYTES = DATA_W / 8;

    logic [LEN_W-1:0] remain_q;

    assign last = (remain_q == LEN_W'(BEAT_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            wr_addr  <= '0;
            remain_q <= '0;
        end else if (load) begin
            rd_addr  <= src_in;
            wr_addr  <= dst_in;
            remain_q <= len_in;
        end else if (step) begin
            rd_addr  <= rd_addr + ADDR_W'(BEAT_BYTES);
            wr_addr  <= wr_addr + ADDR_W'(BEAT_BYTES);
            remain_q <= remain_q - LEN_W'(BEAT_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wr_data <= '0;
        else if (capture) wr_data <= rd_data;
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_mm_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len_q,
    input  logic             bus_gnt,
    input  logic             rd_ack,
    input  logic             rd_err,
    input  logic             wr_ack,
    input  logic             wr_err,
    input  logic             last,
    output logic             busy,
    output logic             bus_req,
    output logic             rd_req,
    output logic             wr_req,
    output logic             load,
    output logic             capture,
    output logic             step,
    output logic             fin,
    output logic             fin_err
);
    localparam int BEAT_LSB = $clog2(DATA_W / 8);

    xfer_state_t state_q, state_d;
    logic        bad_len;
    logic        rd_fire;
    logic        wr_fire;

    assign bad_len = (len_q == '0) || (len_q[BEAT_LSB-1:0] != '0);
    assign rd_fire = rd_req && rd_ack;
    assign wr_fire = wr_req && wr_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go && !bad_len) state_d = ST_ARB;
            ST_ARB:   if (bus_gnt)        state_d = ST_READ;
            ST_READ:  if (rd_fire)        state_d = rd_err ? ST_IDLE : ST_WRITE;
            ST_WRITE: if (wr_fire)        state_d = (wr_err || last) ? ST_IDLE : ST_READ;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        bus_req = 1'b0;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        load    = 1'b0;
        capture = 1'b0;
        step    = 1'b0;
        fin     = 1'b0;
        fin_err = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load    = go && !bad_len;
                fin     = go && bad_len;
                fin_err = 1'b1;
            end
            ST_ARB: begin
                busy    = 1'b1;
                bus_req = 1'b1;
            end
            ST_READ: begin
                busy    = 1'b1;
                bus_req = 1'b1;
                rd_req  = bus_gnt;
                capture = rd_fire && !rd_err;
                fin     = rd_fire && rd_err;
                fin_err = 1'b1;
            end
            ST_WRITE: begin
                busy    = 1'b1;
                bus_req = 1'b1;
                wr_req  = bus_gnt;
                step    = wr_fire && !wr_err;
                fin     = wr_fire && (wr_err || last);
                fin_err = wr_err;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dma_mm_engine.sv
module dma_mm_engine #(
    parameter int CFG_AW = 5,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    input  logic              wr_err
);
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              go;
    logic              st_busy;
    logic              st_done;
    logic              st_err;
    logic              fin;
    logic              fin_err;
    logic              load;
    logic              capture;
    logic              step;
    logic              last;

    dma_cfg_regs #(
        .CFG_AW (CFG_AW),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .eng_busy  (st_busy),
        .fin       (fin),
        .fin_err   (fin_err),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .len_q     (len_q),
        .go        (go),
        .done_q    (st_done),
        .err_q     (st_err),
        .irq       (irq)
    );

    dma_xfer_fsm #(
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .len_q   (len_q),
        .bus_gnt (bus_gnt),
        .rd_ack  (rd_ack),
        .rd_err  (rd_err),
        .wr_ack  (wr_ack),
        .wr_err  (wr_err),
        .last    (last),
        .busy    (st_busy),
        .bus_req (bus_req),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .load    (load),
        .capture (capture),
        .step    (step),
        .fin     (fin),
        .fin_err (fin_err)
    );

    dma_addr_seq #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .capture (capture),
        .step    (step),
        .src_in  (src_q),
        .dst_in  (dst_q),
        .len_in  (len_q),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .last    (last)
    );

endmodule

// File: rtl/dma_mm_engine_sva.sv
module dma_mm_engine_sva #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_err,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ack,
    input logic              wr_err,
    input logic              st_busy,
    input logic              st_done,
    input logic              st_err
);
    p_access_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> (bus_gnt && bus_req));

    p_rd_to_wr_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && !rd_err) |=> (wr_data == $past(rd_data)));

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> $stable(rd_addr));

    p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> ($stable(wr_addr) && $stable(wr_data)));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_busy |-> !(bus_req || rd_req || wr_req));

    p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_done);

    p_rd_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> (!st_busy && !bus_req && st_done && st_err));

    p_wr_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && wr_err) |=> (!st_busy && !bus_req && st_done && st_err));

    p_one_job_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_busy && st_done));

endmodule

bind dma_mm_engine dma_mm_engine_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .rd_err  (rd_err),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ack  (wr_ack),
    .wr_err  (wr_err),
    .st_busy (st_busy),
    .st_done (st_done),
    .st_err  (st_err)
);

// File: tb/dma_mm_engine_tb.sv
`timescale 1ns/1ps
module dma_mm_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, bus_req, rd_req, wr_req;
    logic        bus_gnt = 1'b0;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_mm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err)
    );

    // ---------------- bus models ----------------
    logic [31:0] mem [0:255];
    int          gnt_lat = 1, rd_lat = 0, wr_lat = 0;
    int          gcnt = 0, rcnt = 0, wcnt = 0;
    logic [31:0] bad_rd = 32'hFFFF_FFFF, bad_wr = 32'hFFFF_FFFF;

    always @(posedge clk) begin
        if (!bus_req) begin
            bus_gnt <= 1'b0;
            gcnt    <= 0;
        end else if (gcnt >= gnt_lat) begin
            bus_gnt <= 1'b1;
        end else begin
            gcnt <= gcnt + 1;
        end
    end

    always @(posedge clk) begin
        rd_ack <= 1'b0;
        rd_err <= 1'b0;
        if (rd_req && !rd_ack) begin
            if (rcnt >= rd_lat) begin
                rd_ack  <= 1'b1;
                rd_data <= mem[rd_addr[9:2]];
                rd_err  <= (rd_addr == bad_rd);
                rcnt    <= 0;
            end else rcnt <= rcnt + 1;
        end
    end

    always @(posedge clk) begin
        wr_ack <= 1'b0;
        wr_err <= 1'b0;
        if (wr_req && !wr_ack) begin
            if (wcnt >= wr_lat) begin
                wr_ack <= 1'b1;
                wr_err <= (wr_addr == bad_wr);
                if (wr_addr != bad_wr) mem[wr_addr[9:2]] <= wr_data;
                wcnt <= 0;
            end else wcnt <= wcnt + 1;
        end
    end

    // ---------------- port monitors (sampled at negedge) ----------------
    int          rd_beats, wr_beats, exp_words;
    int          nogrant_viol, order_viol, addr_viol, hold_viol, drop_viol, drop_seen, req_seen;
    logic [31:0] exp_src, exp_dst, last_rd;
    logic        drop_pend = 1'b0;
    logic        rd_pend = 1'b0, wr_pend = 1'b0;
    logic [31:0] rd_pa, wr_pa, wr_pd;

    task automatic mon_clear();
        rd_beats = 0; wr_beats = 0;
        nogrant_viol = 0; order_viol = 0; addr_viol = 0; hold_viol = 0;
        drop_viol = 0; drop_seen = 0; req_seen = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) req_seen++;
            if ((rd_req || wr_req) && !bus_gnt) nogrant_viol++;
            if (drop_pend) begin
                drop_seen++;
                if (bus_req) drop_viol++;
                drop_pend = 1'b0;
            end
            if (rd_pend && rd_req && rd_addr != rd_pa) hold_viol++;
            if (wr_pend && wr_req && (wr_addr != wr_pa || wr_data != wr_pd)) hold_viol++;
            rd_pend = rd_req && !rd_ack; rd_pa = rd_addr;
            wr_pend = wr_req && !wr_ack; wr_pa = wr_addr; wr_pd = wr_data;
            if (rd_req && rd_ack) begin
                if (rd_addr != exp_src + 32'(4 * rd_beats)) addr_viol++;
                last_rd = rd_data;
                rd_beats++;
            end
            if (wr_req && wr_ack) begin
                if (wr_addr != exp_dst + 32'(4 * wr_beats)) addr_viol++;
                if (wr_beats >= rd_beats || wr_data != last_rd) order_viol++;
                wr_beats++;
                if (wr_beats == exp_words) drop_pend = 1'b1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            cfg_read(5'h10, s);
            if (!s[0]) break;
        end
    endtask

    task automatic setup_job(logic [31:0] s, logic [31:0] d, int words);
        for (int i = 0; i < words; i++) begin
            mem[s[9:2] + 8'(i)] = 32'hA500_0000 ^ (s + 32'(i * 4)) ^ 32'(i * 7919);
            mem[d[9:2] + 8'(i)] = 32'h0;
        end
        exp_src = s; exp_dst = d; exp_words = words;
        mon_clear();
        cfg_write(5'h00, s);
        cfg_write(5'h04, d);
        cfg_write(5'h08, 32'(words * 4));
    endtask

    task automatic ack_done();
        logic [31:0] s;
        cfg_write(5'h10, 32'h2);
        cfg_read(5'h10, s);
        chk("R6 status after clear", s, 32'h0);
        chk("R6 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) begin
            cfg_read(5'(i * 4), v);
            chk("R1 reset register value", v, 32'h0);
        end
        chk("R1 reset irq/bus_req", {30'b0, irq, bus_req}, 32'h0);
    endtask

    task automatic t_copy(int words, int gl, int rl, int wl, string tag);
        logic [31:0] s, src, dst;
        gnt_lat = gl; rd_lat = rl; wr_lat = wl;
        src = 32'h40 + 32'(words * 4); dst = 32'h200 + 32'(words * 8);
        setup_job(src, dst, words);
        cfg_write(5'h0C, 32'h3);
        cfg_read(5'h10, s);
        chk({tag, " R2 busy after start"}, s, 32'h1);
        chk({tag, " R2 bus_req after start"}, {31'b0, bus_req}, 32'h1);
        wait_idle();
        cfg_read(5'h10, s);
        chk({tag, " R5 status done"}, s, 32'h2);
        chk({tag, " R6 irq with enable"}, {31'b0, irq}, 32'h1);
        chk({tag, " R5 bus_req low after final ack"}, 32'(drop_viol), 32'h0);
        chk({tag, " R5 final-ack cycle observed"}, 32'(drop_seen), 32'h1);
        chk({tag, " R2 access without grant"}, 32'(nogrant_viol), 32'h0);
        chk({tag, " R3 address sequence"}, 32'(addr_viol), 32'h0);
        chk({tag, " R3 write after read with its data"}, 32'(order_viol), 32'h0);
        chk({tag, " R3 beat count"}, 32'(wr_beats), 32'(words));
        chk({tag, " R4 request held stable"}, 32'(hold_viol), 32'h0);
        for (int i = 0; i < words; i++)
            chk({tag, " R3 destination word"}, mem[dst[9:2] + 8'(i)], mem[src[9:2] + 8'(i)]);
        ack_done();
    endtask

    task automatic t_bad_len(logic [31:0] len, string tag);
        logic [31:0] s;
        mon_clear(); exp_words = -1;
        cfg_write(5'h08, len);
        cfg_write(5'h0C, 32'h3);
        cfg_read(5'h10, s);
        chk({tag, " R7 done+error"}, s, 32'h6);
        repeat (3) @(negedge clk);
        chk({tag, " R7 no bus request"}, 32'(req_seen), 32'h0);
        chk({tag, " R6 irq"}, {31'b0, irq}, 32'h1);
        ack_done();
    endtask

    task automatic t_lock();
        logic [31:0] s, v;
        gnt_lat = 25; rd_lat = 0; wr_lat = 0;
        setup_job(32'h10, 32'h300, 3);
        cfg_write(5'h0C, 32'h3);
        cfg_write(5'h00, 32'h0000_0080);
        cfg_write(5'h08, 32'h40);
        cfg_write(5'h0C, 32'h3);
        cfg_read(5'h00, v);
        chk("R9 source write ignored while busy", v, 32'h10);
        cfg_read(5'h08, v);
        chk("R9 length write ignored while busy", v, 32'hC);
        wait_idle();
        chk("R9 busy job beat count", 32'(wr_beats), 32'd3);
        mon_clear();
        cfg_write(5'h04, 32'h100);
        cfg_write(5'h0C, 32'h3);
        repeat (4) @(negedge clk);
        chk("R9 start ignored while done", 32'(req_seen), 32'h0);
        cfg_read(5'h04, v);
        chk("R9 destination write ignored while done", v, 32'h300);
        cfg_read(5'h10, s);
        chk("R9 status still done", s, 32'h2);
        ack_done();
    endtask

    task automatic t_rd_err();
        logic [31:0] s;
        gnt_lat = 2; rd_lat = 1; wr_lat = 1;
        setup_job(32'h20, 32'h280, 4);
        bad_rd = 32'h28;
        cfg_write(5'h0C, 32'h3);
        wait_idle();
        repeat (3) @(negedge clk);
        cfg_read(5'h10, s);
        chk("R8 read error status", s, 32'h6);
        chk("R8 reads stop at error", 32'(rd_beats), 32'd3);
        chk("R8 writes stop at error", 32'(wr_beats), 32'd2);
        chk("R8 bus_req released", {31'b0, bus_req}, 32'h0);
        chk("R8 word after error untouched", mem[8'hA2], 32'h0);
        bad_rd = 32'hFFFF_FFFF;
        ack_done();
    endtask

    task automatic t_wr_err();
        logic [31:0] s;
        gnt_lat = 1; rd_lat = 0; wr_lat = 2;
        setup_job(32'h60, 32'h2C0, 4);
        bad_wr = 32'h2C4;
        cfg_write(5'h0C, 32'h1);
        wait_idle();
        repeat (3) @(negedge clk);
        cfg_read(5'h10, s);
        chk("R8 write error status", s, 32'h6);
        chk("R8 reads after write error", 32'(rd_beats), 32'd2);
        chk("R8 write beats incl errored", 32'(wr_beats), 32'd2);
        chk("R6 irq masked when disabled", {31'b0, irq}, 32'h0);
        chk("R8 first word copied", mem[8'hB0], mem[8'h18]);
        bad_wr = 32'hFFFF_FFFF;
        ack_done();
    endtask

    task automatic t_misaligned_cfg();
        logic [31:0] v;
        cfg_write(5'h01, 32'hDEAD_BEEF);
        cfg_read(5'h00, v);
        chk("R1 misaligned write ignored", v, 32'h60);
    endtask

    initial begin
        mon_clear();
        exp_words = -1; exp_src = '0; exp_dst = '0; last_rd = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_copy(1, 1, 0, 0, "single");
        t_copy(4, 3, 0, 0, "basic");
        t_copy(6, 8, 5, 3, "slow");
        t_bad_len(32'h0, "zero");
        t_bad_len(32'h6, "odd");
        t_lock();
        t_rd_err();
        t_wr_err();
        t_misaligned_cfg();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule